// File: doc/BRIEF.md
# SPI Master Frame Sequencer

This block is the transmit and receive engine of a synchronous serial master that uses one clock mode. The serial clock rests high. Received data is captured on falling clock edges and transmit data is launched on rising clock edges. Words come from a transmit queue over a valid/ready handshake. Each word is shifted out most significant bit first, with a length chosen between 4 and 16 bits. A word is received at the same time as each word is sent, and it is returned right-justified with a one-cycle valid pulse.

A frame opens when the block is enabled and a word is waiting. The frame-select line and the active-low transmit pad enable fall together. The clock then drops for a lead half period, and rises as the first bit is launched. A word that is already waiting when the last bit of the current word is captured follows with no gap, and the frame stays open. Once no word follows, the clock returns to its resting level. Frame select then closes one full serial period after the last capture. The active-low clock pad enable follows a master/slave configuration input.

The serial half period is a whole number of system clocks, taken from an input when a frame opens. Every pad output comes from a register.

Top module: `spi_frame_master`

## Requirements
- R1: Out of reset, and whenever no frame is open, the outputs are at rest: `cs_n`=1, `sclk`=1, `mosi_oe_n`=1 and `mosi`=0. `mosi_oe_n` always equals `cs_n`.
- R2: `sclk_oe_n` is the inverse of `is_master`, registered, so it changes one system clock after the input.
- R3: A frame opens only on a cycle where `tx_valid`, `tx_ready` and `enable` are all high. On the next system clock, `cs_n` and `mosi_oe_n` go low and `sclk` goes low.
- R4: Let H = `half_cycles`, or 1 when that input is 0, latched when the frame opens. After H system clocks, `sclk` rises and the first bit appears on `mosi`. Each later half period also lasts H system clocks.
- R5: While `cs_n` is low, `mosi` changes only on the system clock where `sclk` rises. `miso` is sampled on the system clock edge where `sclk` falls.
- R6: The length L of a word is `word_len` clamped to the range 4 to 16, taken when the word is accepted. The bits sent are `tx_data[L-1:0]`, most significant first. Higher bits of `tx_data` are ignored.
- R7: When no word follows, `sclk` returns high H clocks after the last fall. `cs_n` and `mosi_oe_n` rise 2H clocks after the last fall.
- R8: `tx_ready` is high when `enable` is high and either no frame is open or the current cycle captures the final bit of a word. A word accepted at a final capture starts with a rising edge H clocks later, and `cs_n` stays low.
- R9: `rx_valid` is high for exactly one cycle, the cycle after the final capture of a word. `rx_data` then holds the L received bits right-justified, with the upper bits at 0.
- R10: `rx_overrun` is high for one cycle, the cycle after an `rx_valid` cycle in which `rx_ready` was low.
- R11: With `enable` low, no frame opens even when `tx_valid` is high. If `enable` falls during a word, that word completes and the frame closes as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Allows new words to be accepted |
| is_master | input | 1 | Master (1) or slave (0) configuration |
| word_len | input | 5 | Bits per word, clamped to 4..16 |
| half_cycles | input | 8 | System clocks per serial half period (0 is read as 1) |
| tx_valid | input | 1 | Transmit word available |
| tx_data | input | 16 | Transmit word, right-justified |
| tx_ready | output | 1 | Transmit word accepted this cycle when valid |
| rx_valid | output | 1 | One-cycle pulse: received word present |
| rx_data | output | 16 | Received word, right-justified |
| rx_ready | input | 1 | Receiver can take the word |
| rx_overrun | output | 1 | A received word was not taken |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Frame select, active low |
| mosi | output | 1 | Serial data out |
| mosi_oe_n | output | 1 | Data pad output enable, active low |
| sclk_oe_n | output | 1 | Clock pad output enable, active low |

## Verification
The hardest case to reach is the word-to-word seam inside one frame. The next word has to be valid on exactly the system clock that captures the final bit. `enable` also has to be read there, and a change of `word_len` must take effect only for the new word. The stimulus keeps several words queued while it changes the length and the half period between frames. It drops `enable` in the middle of a word that has a follower waiting. The behavioural model then shows whether the seam keeps `cs_n` low, and whether the drop closes the frame with the follower left unsent.

// File: rtl/spi_fm_pkg.sv
// Package: shared types for the SPI frame sequencer.
// Assumes nothing beyond plain SystemVerilog.
package spi_fm_pkg;
    // Sequencer phases in the order a frame passes through them.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,  // no frame open
        PH_LEAD = 3'd1,  // frame select low, clock low, before first bit
        PH_HIGH = 3'd2,  // clock high half of a bit
        PH_LOW  = 3'd3,  // clock low half after a capture
        PH_TAIL = 3'd4   // clock back high, frame select closing
    } fm_phase_t;

    // Shortest word the sequencer will send.
    localparam int FM_MIN_LEN = 4;
endpackage

// File: rtl/spi_fm_halfper.sv
// spi_fm_halfper: counts system clocks inside one serial half period.
// Assumes half_q >= 1, and that half_q stays stable while run is high.
module spi_fm_halfper #(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] half_q,
    output logic              tick
);
    logic [HALF_W-1:0] cnt;

    // tick marks the last system clock of a half period.
    assign tick = run && (cnt == half_q - HALF_W'(1));

    // Counter: held at zero when stopped, wraps on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + HALF_W'(1);
        end
    end
endmodule

// File: rtl/spi_fm_txshift.sv
// spi_fm_txshift: holds the outgoing word left-aligned and counts bits launched.
// Assumes load_len lies in 1..MAX_W; load and shift are never both high.
module spi_fm_txshift #(
    parameter int MAX_W = 16,
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [MAX_W-1:0] load_data,
    input  logic [LEN_W-1:0] load_len,
    input  logic             shift,
    output logic             msb,
    output logic             word_done
);
    logic [MAX_W-1:0] sh;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] sent;
    logic [LEN_W-1:0] shamt;

    assign shamt     = LEN_W'(MAX_W) - load_len;
    assign msb       = sh[MAX_W-1];
    assign word_done = (sent == len_q);

    // Shift register: align a new word, or move the next bit into place.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh    <= '0;
            len_q <= LEN_W'(MAX_W);
            sent  <= LEN_W'(MAX_W);
        end else if (load) begin
            sh    <= load_data << shamt;
            len_q <= load_len;
            sent  <= '0;
        end else if (shift) begin
            sh    <= {sh[MAX_W-2:0], 1'b0};
            sent  <= sent + LEN_W'(1);
        end
    end
endmodule

// File: rtl/spi_fm_rxshift.sv
// spi_fm_rxshift: gathers sampled bits and hands back each finished word.
// Assumes capture is high for one system clock per falling serial edge.
module spi_fm_rxshift #(
    parameter int MAX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             last,
    input  logic             miso,
    input  logic             rx_ready,
    output logic             rx_valid,
    output logic [MAX_W-1:0] rx_data,
    output logic             rx_overrun
);
    logic [MAX_W-1:0] sh;
    logic [MAX_W-1:0] nxt;

    assign nxt = {sh[MAX_W-2:0], miso};

    // Shift in a sampled bit; on the final bit publish the word and clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh       <= '0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (capture) begin
                if (last) begin
                    rx_data  <= nxt;
                    rx_valid <= 1'b1;
                    sh       <= '0;
                end else begin
                    sh <= nxt;
                end
            end
        end
    end

    // Overrun: raised for the word that found the receiver not ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_overrun <= 1'b0;
        end else begin
            rx_overrun <= rx_valid && !rx_ready;
        end
    end

    // R10
    overrun_follows_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |-> $past(rx_valid) && !$past(rx_ready));
endmodule

// File: rtl/spi_frame_master.sv
// spi_frame_master: serial master frame sequencer with a high-resting clock,
// capture on falling edges and launch on rising edges.
// Assumes a synchronous active-low reset. word_len and half_cycles may change
// at any time and are read only at word accept and at frame open.
module spi_frame_master
    import spi_fm_pkg::*;
#(
    parameter int MAX_W  = 16,
    parameter int HALF_W = 8,
    localparam int LEN_W = $clog2(MAX_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              is_master,
    input  logic [LEN_W-1:0]  word_len,
    input  logic [HALF_W-1:0] half_cycles,
    input  logic              tx_valid,
    input  logic [MAX_W-1:0]  tx_data,
    output logic              tx_ready,
    output logic              rx_valid,
    output logic [MAX_W-1:0]  rx_data,
    input  logic              rx_ready,
    output logic              rx_overrun,
    input  logic              miso,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi,
    output logic              mosi_oe_n,
    output logic              sclk_oe_n
);
    fm_phase_t         ph;
    logic [HALF_W-1:0] half_q;
    logic              tick;
    logic              tx_msb;
    logic              word_done;
    logic [LEN_W-1:0]  len_eff;
    logic              accept;
    logic              launch;
    logic              capture;

    // Clamp the requested length into the supported range.
    always_comb begin
        if (word_len < LEN_W'(FM_MIN_LEN)) begin
            len_eff = LEN_W'(FM_MIN_LEN);
        end else if (word_len > LEN_W'(MAX_W)) begin
            len_eff = LEN_W'(MAX_W);
        end else begin
            len_eff = word_len;
        end
    end

    // Handshake: open a frame, or chain a word at the final capture.
    assign tx_ready = enable && ((ph == PH_IDLE) ||
                                 ((ph == PH_HIGH) && tick && word_done));
    assign accept   = tx_valid && tx_ready;
    assign capture  = (ph == PH_HIGH) && tick;
    assign launch   = tick && ((ph == PH_LEAD) || ((ph == PH_LOW) && !word_done));

    spi_fm_halfper #(.HALF_W(HALF_W)) u_halfper (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (ph != PH_IDLE),
        .half_q (half_q),
        .tick   (tick)
    );

    spi_fm_txshift #(.MAX_W(MAX_W), .LEN_W(LEN_W)) u_txshift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_data (tx_data),
        .load_len  (len_eff),
        .shift     (launch),
        .msb       (tx_msb),
        .word_done (word_done)
    );

    spi_fm_rxshift #(.MAX_W(MAX_W)) u_rxshift (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .last       (word_done),
        .miso       (miso),
        .rx_ready   (rx_ready),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_overrun (rx_overrun)
    );

    // Clock pad enable follows the configuration, registered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_oe_n <= 1'b1;
        end else begin
            sclk_oe_n <= !is_master;
        end
    end

    // Phase sequencer: drives frame select, clock, data and data pad enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph        <= PH_IDLE;
            half_q    <= HALF_W'(1);
            sclk      <= 1'b1;
            cs_n      <= 1'b1;
            mosi      <= 1'b0;
            mosi_oe_n <= 1'b1;
        end else begin
            case (ph)
                PH_IDLE: begin
                    if (accept) begin
                        ph        <= PH_LEAD;
                        half_q    <= (half_cycles == '0) ? HALF_W'(1) : half_cycles;
                        cs_n      <= 1'b0;
                        mosi_oe_n <= 1'b0;
                        sclk      <= 1'b0;
                    end
                end
                PH_LEAD: begin
                    if (tick) begin
                        ph   <= PH_HIGH;
                        sclk <= 1'b1;
                        mosi <= tx_msb;
                    end
                end
                PH_HIGH: begin
                    if (tick) begin
                        ph   <= PH_LOW;
                        sclk <= 1'b0;
                    end
                end
                PH_LOW: begin
                    if (tick) begin
                        sclk <= 1'b1;
                        if (!word_done) begin
                            ph   <= PH_HIGH;
                            mosi <= tx_msb;
                        end else begin
                            ph <= PH_TAIL;
                        end
                    end
                end
                PH_TAIL: begin
                    if (tick) begin
                        ph        <= PH_IDLE;
                        cs_n      <= 1'b1;
                        mosi_oe_n <= 1'b1;
                        mosi      <= 1'b0;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // R1
    pad_enable_tracks_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mosi_oe_n == cs_n);
    // R1
    rest_clock_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);
    // R2
    clk_pad_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_master |=> !sclk_oe_n);
    // R2
    clk_pad_slave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_master |=> sclk_oe_n);
    // R3
    open_drops_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> !sclk);
    // R5
    launch_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mosi) && !cs_n) |-> $rose(sclk));
    // R9
    rx_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
endmodule

// File: tb/spi_frame_master_tb.sv
module spi_frame_master_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        is_master = 1'b1;
    logic [4:0]  word_len = 5'd8;
    logic [7:0]  half_cycles = 8'd1;
    logic        tx_valid = 1'b0;
    logic [15:0] tx_data = '0;
    logic        tx_ready;
    logic        rx_valid;
    logic [15:0] rx_data;
    logic        rx_ready = 1'b1;
    logic        rx_overrun;
    logic        miso = 1'b0;
    logic        sclk, cs_n, mosi, mosi_oe_n, sclk_oe_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_frame_master u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .is_master(is_master),
        .word_len(word_len), .half_cycles(half_cycles),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .rx_overrun(rx_overrun), .miso(miso), .sclk(sclk), .cs_n(cs_n),
        .mosi(mosi), .mosi_oe_n(mosi_oe_n), .sclk_oe_n(sclk_oe_n)
    );

    int total = 0;
    int bad = 0;
    logic [15:0] txq[$];
    logic [15:0] lfsr = 16'hACE1;

    // Reference model state
    int m_ph = 0, m_left = 0, m_h = 1, m_len = 8, m_idx = 0;
    logic [15:0] m_word = '0;
    int m_rx = 0;
    logic e_sclk = 1, e_cs = 1, e_mosi = 0, e_oe = 1, e_sckoe = 1;
    logic e_rxv = 0, e_ovr = 0;
    logic [15:0] e_rxd = '0;
    bit started = 0;

    function automatic int clamp_len(input int v);
        if (v < 4) return 4;
        if (v > 16) return 16;
        return v;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model, stepped on each rising clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_left = 0; m_h = 1; m_rx = 0;
            e_sclk = 1; e_cs = 1; e_mosi = 0; e_oe = 1; e_sckoe = 1;
            e_rxv = 0; e_ovr = 0; e_rxd = '0;
            started = 1;
        end else begin
            e_ovr = e_rxv && !rx_ready;
            e_rxv = 0;
            e_sckoe = !is_master;
            if (m_ph == 0) begin
                if (enable && tx_valid) begin
                    m_word = tx_data; m_len = clamp_len(int'(word_len));
                    void'(txq.pop_front());
                    m_h = (half_cycles == 0) ? 1 : int'(half_cycles);
                    m_left = m_h; m_ph = 1; m_idx = m_len; m_rx = 0;
                    e_cs = 0; e_oe = 0; e_sclk = 0;
                end
            end else if (m_left > 1) begin
                m_left--;
            end else begin
                m_left = m_h;
                case (m_ph)
                    1: begin
                        m_idx--; e_mosi = m_word[m_idx]; e_sclk = 1; m_ph = 2;
                    end
                    2: begin
                        e_sclk = 0; m_ph = 3;
                        m_rx = (m_rx << 1) | int'(miso);
                        if (m_idx == 0) begin
                            e_rxv = 1; e_rxd = 16'(m_rx); m_rx = 0;
                            if (enable && tx_valid) begin
                                m_word = tx_data; m_len = clamp_len(int'(word_len));
                                void'(txq.pop_front());
                                m_idx = m_len;
                            end
                        end
                    end
                    3: begin
                        e_sclk = 1;
                        if (m_idx > 0) begin
                            m_idx--; e_mosi = m_word[m_idx]; m_ph = 2;
                        end else begin
                            m_ph = 4;
                        end
                    end
                    default: begin
                        m_ph = 0; e_cs = 1; e_oe = 1; e_mosi = 0;
                    end
                endcase
            end
        end
    end

    // Input driver: source queue and serial data in, updated after each edge.
    always @(posedge clk) begin
        #1;
        tx_valid = (txq.size() > 0);
        tx_data  = (txq.size() > 0) ? txq[0] : 16'h0;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        miso = lfsr[0];
    end

    // Comparison on every clock, away from the active edge.
    logic prev_cs = 1, prev_sclk = 1;
    int falls = 0, last_falls = 0;
    always @(negedge clk) begin
        if (started) begin
            chk("R1 R3 R7 R8 R11 cs_n", cs_n, e_cs);
            chk("R1 R4 R7 sclk", sclk, e_sclk);
            chk("R5 R6 mosi", mosi, e_mosi);
            chk("R1 R3 R7 mosi_oe_n", mosi_oe_n, e_oe);
            chk("R2 sclk_oe_n", sclk_oe_n, e_sckoe);
            chk("R9 rx_valid", rx_valid, e_rxv);
            if (e_rxv) chk("R9 R5 rx_data", rx_data, e_rxd);
            chk("R10 rx_overrun", rx_overrun, e_ovr);
            chk("R8 R11 tx_ready", tx_ready,
                enable && (m_ph == 0 || (m_ph == 2 && m_left == 1 && m_idx == 0)));
            if (!sclk && prev_sclk && !cs_n && !prev_cs) falls++;
            if (cs_n && !prev_cs) begin last_falls = falls; falls = 0; end
            prev_cs = cs_n; prev_sclk = sclk;
        end
    end

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 4) begin
            @(posedge clk);
            if (m_ph == 0 && txq.size() == 0) quiet++; else quiet = 0;
        end
        #1;
    endtask

    task automatic cfg(input int len, input int half);
        @(posedge clk); #1;
        word_len = 5'(len); half_cycles = 8'(half);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: rest levels out of reset (sampled with reset still held)
        chk("R1 reset cs_n", cs_n, 1);
        chk("R1 reset sclk", sclk, 1);
        chk("R1 reset mosi_oe_n", mosi_oe_n, 1);
        rst_n = 1;
        repeat (2) @(posedge clk); #1;

        // R11: enable low, word waiting, no frame opens
        txq.push_back(16'h00C3);
        repeat (40) @(posedge clk); #1;
        chk("R11 queue untouched while disabled", txq.size(), 1);
        chk("R11 cs_n stays high", cs_n, 1);
        enable = 1;
        wait_idle();
        chk("R6 captures for 8-bit word", last_falls, 8);

        // R4 R7: 4-bit word, wide half period
        cfg(4, 3);
        txq.push_back(16'hFFF9);
        wait_idle();
        chk("R6 captures for 4-bit word", last_falls, 4);

        // R8 R10: back-to-back 16-bit burst, receiver not ready
        cfg(16, 2);
        rx_ready = 0;
        txq.push_back(16'hA55A); txq.push_back(16'h0F0F); txq.push_back(16'h8001);
        wait_idle();
        chk("R8 three chained words in one frame", last_falls, 48);
        rx_ready = 1;

        // R8 R6: length change between chained words
        cfg(5, 1);
        txq.push_back(16'h0015);
        txq.push_back(16'h0123);
        repeat (4) @(posedge clk); #1;
        word_len = 5'd9;
        wait_idle();
        chk("R6 R8 mixed lengths chained", last_falls, 14);

        // R11: enable dropped mid-word with follower waiting
        cfg(12, 2);
        txq.push_back(16'h0ABC); txq.push_back(16'h0DEF);
        repeat (12) @(posedge clk); #1;
        enable = 0;
        while (!cs_n) @(posedge clk);
        repeat (20) @(posedge clk); #1;
        chk("R11 current word finished", last_falls, 12);
        chk("R11 follower not taken", txq.size(), 1);
        enable = 1;
        wait_idle();

        // R6: clamping of lengths, R4: zero half period
        cfg(2, 0);
        txq.push_back(16'h0007);
        wait_idle();
        chk("R6 short length clamped", last_falls, 4);
        cfg(20, 1);
        txq.push_back(16'h1234);
        wait_idle();
        chk("R6 long length clamped", last_falls, 16);

        // R2: slave configuration drives clock pad enable high
        @(posedge clk); #1; is_master = 0;
        repeat (3) @(posedge clk); #1;
        chk("R2 slave disables clock pad", sclk_oe_n, 1);
        is_master = 1;
        repeat (3) @(posedge clk); #1;
        chk("R2 master enables clock pad", sclk_oe_n, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule